// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier

This block forms the unsigned product of two W-bit operands over several clock cycles. It uses one adder and three working registers. A start pulse copies the first operand, zero-extended, into a 2W-bit multiplicand register and copies the second operand into a W-bit multiplier register. The same pulse clears a 2W-bit accumulator.

A small controller then looks only at bit 0 of the multiplier register. When that bit is set, the controller spends one cycle adding the multiplicand into the accumulator and clears the bit. When the bit is clear, the controller spends one cycle shifting the multiplicand left and the multiplier right. After W shifts the accumulator holds the full product and a one-cycle done pulse is raised. The controller's clear, add and shift strobes are brought out so that the schedule can be observed.

The run length depends on the data: it is W plus the number of set bits in the second operand. The product output keeps its value until the next accepted start.

Top module: `shift_add_mul`

## Requirements
- R1: When start is high while the block is idle, stb_clear is high in that same cycle. At the next edge the accumulator, and with it the product, becomes 0, the multiplicand register loads op_a zero-extended to 2W bits, and the multiplier register loads op_b.
- R2: In a run cycle where bit 0 of the multiplier register is 0, stb_shift is high. In that cycle the multiplicand shifts left by one, the multiplier shifts right by one, and nothing is added.
- R3: In a run cycle where bit 0 of the multiplier register is 1, stb_add is high, the multiplicand is added into the accumulator, and that bit is cleared. The cycle that follows is therefore always a shift cycle.
- R4: In every cycle at most one of stb_clear, stb_add and stb_shift is high.
- R5: Count the edge that samples start as edge 0. Done is high after edge W + ones(op_b) and low again after the next edge. While done is high, product equals op_a * op_b as a full 2W-bit value. This also holds for operands of zero and of all ones.
- R6: A start that arrives while a run or its done cycle is in progress is ignored: stb_clear stays low, and the current result and its timing are unchanged.
- R7: While rst_n is low the block is idle: done and all three strobes are low and product is 0.
- R8: Product changes only at the edge after a stb_clear or stb_add cycle. In particular, it stays stable from done until the next accepted start.
- R9: Each operation gives exactly ones(op_b) stb_add cycles and exactly W stb_shift cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Start request, accepted only when idle |
| op_a | input | W | Multiplicand operand (unsigned) |
| op_b | input | W | Multiplier operand (unsigned) |
| product | output | 2W | Accumulator contents, which are the product after done |
| done | output | 1 | One-cycle pulse when the product is complete |
| stb_clear | output | 1 | Controller clear/load strobe |
| stb_add | output | 1 | Controller add strobe |
| stb_shift | output | 1 | Controller shift strobe |

## Verification
The strobes are combinational decodes of the controller state and of bit 0 of the multiplier register. The bench therefore reads them one time step after it drives inputs at the falling edge: stb_clear in the cycle start is applied, and stb_add and stb_shift in each run cycle.

The bench does not wait for done. It counts rising edges from the edge that samples start and expects done after exactly W + ones(op_b) edges. It checks the product in that cycle, and checks that done is low one edge later. To test R8, the product is read again several idle cycles later. To test R6, a second start with different operands is held through run cycles, and the bench confirms that the timing and the result of the first operation are unchanged.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } mul_state_e;
endpackage

// File: rtl/mul_adder.sv
// Ripple-carry adder of WIDTH bits. The top carry is not produced, because the
// product always fits in WIDTH bits.
module mul_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] sum
);
  logic [WIDTH-1:0] carry;

  assign carry[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign sum[i] = a[i] ^ b[i] ^ carry[i];
    if (i < WIDTH - 1) begin : g_carry
      assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
    end
  end
endmodule

// File: rtl/mul_ctrl.sv
// Controller: one add cycle for each set multiplier bit, and one shift cycle
// for each multiplier bit.
module mul_ctrl
  import mul_pkg::*;
#(
  parameter int W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic mplier_lsb,
  output logic stb_clear,
  output logic stb_add,
  output logic stb_shift,
  output logic done
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST_SHIFT = CW'(W - 1);

  mul_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  // Strobe decode
  always_comb begin
    stb_clear = (state_q == ST_IDLE) && start;
    stb_add   = (state_q == ST_RUN) && mplier_lsb;
    stb_shift = (state_q == ST_RUN) && !mplier_lsb;
    done      = (state_q == ST_DONE);
  end

  // Next state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_RUN;
          cnt_d   = '0;
        end
      end
      ST_RUN: begin
        if (stb_shift) begin
          cnt_d = cnt_q + CW'(1);
          if (cnt_q == LAST_SHIFT) state_d = ST_DONE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/mul_datapath.sv
// Datapath: a 2W-bit multiplicand, a W-bit multiplier and a 2W-bit accumulator.
module mul_datapath #(
  parameter int W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           add_en,
  input  logic           shift_en,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic           mplier_lsb,
  output logic [2*W-1:0] acc
);
  localparam int P = 2 * W;

  logic [P-1:0] mcand_q, mcand_d;
  logic [W-1:0] mplier_q, mplier_d;
  logic [P-1:0] acc_q, acc_d, sum;
  logic         mcand_en, mplier_en, acc_en;

  mul_adder #(.WIDTH(P)) i_adder (
    .a   (acc_q),
    .b   (mcand_q),
    .sum (sum)
  );

  always_comb begin
    mcand_en  = load | shift_en;
    mplier_en = load | shift_en | add_en;
    acc_en    = load | add_en;

    mcand_d = load ? {{W{1'b0}}, op_a} : {mcand_q[P-2:0], 1'b0};

    if (load)          mplier_d = op_b;
    else if (shift_en) mplier_d = {1'b0, mplier_q[W-1:1]};
    else               mplier_d = {mplier_q[W-1:1], 1'b0};

    acc_d = load ? '0 : sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mcand_q <= '0;
    else if (mcand_en) mcand_q <= mcand_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mplier_q <= '0;
    else if (mplier_en) mplier_q <= mplier_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign mplier_lsb = mplier_q[0];
  assign acc        = acc_q;
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic [2*W-1:0] product,
  output logic           done,
  output logic           stb_clear,
  output logic           stb_add,
  output logic           stb_shift
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       mplier_lsb;

  // Reset is applied at once and released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  mul_ctrl #(.W(W)) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (start),
    .mplier_lsb (mplier_lsb),
    .stb_clear  (stb_clear),
    .stb_add    (stb_add),
    .stb_shift  (stb_shift),
    .done       (done)
  );

  mul_datapath #(.W(W)) i_dp (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load       (stb_clear),
    .add_en     (stb_add),
    .shift_en   (stb_shift),
    .op_a       (op_a),
    .op_b       (op_b),
    .mplier_lsb (mplier_lsb),
    .acc        (product)
  );
endmodule

// File: rtl/mul_chk.sv
module mul_chk #(
  parameter int W = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           done,
  input logic           stb_clear,
  input logic           stb_add,
  input logic           stb_shift,
  input logic [2*W-1:0] product
);
  localparam int SW = $clog2(W + 1) + 1;
  logic [SW-1:0] shifts_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shifts_q <= '0;
    else if (stb_clear) shifts_q <= '0;
    else if (stb_shift) shifts_q <= shifts_q + SW'(1);
  end

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb_clear, stb_add, stb_shift}));

  // R3
  add_then_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_add |=> stb_shift);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  shift_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (shifts_q == SW'(W)));

  // R1
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_clear |=> (product == '0));

  // R8
  product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb_add && !stb_clear) |=> $stable(product));
endmodule

bind shift_add_mul mul_chk #(.W(W)) i_mul_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .done      (done),
  .stb_clear (stb_clear),
  .stb_add   (stb_add),
  .stb_shift (stb_shift),
  .product   (product)
);

// File: tb/test_shift_add_mul.sv
`timescale 1ns/1ps
module test_shift_add_mul;
  localparam int W = 4;
  localparam int P = 2 * W;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic [W-1:0] op_a, op_b;
  logic [P-1:0] product;
  logic         done, stb_clear, stb_add, stb_shift;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  shift_add_mul #(.W(W)) i_shift_add_mul (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .product(product), .done(done), .stb_clear(stb_clear),
    .stb_add(stb_add), .stb_shift(stb_shift)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [P-1:0] ref_prod(input logic [W-1:0] a, input logic [W-1:0] b);
    return P'(a) * P'(b);
  endfunction

  function automatic int ones(input logic [W-1:0] b);
    int n = 0;
    for (int i = 0; i < W; i++) n += int'(b[i]);
    return n;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Runs one multiplication. If disturb is set, a second start with other
  // operands is held through run cycles 1 and 2 (R6).
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input bit disturb);
    int e = 0;
    int adds = 0;
    int shifts = 0;
    int lat = W + ones(b);
    bit clr_seen = 0;
    logic [P-1:0] held;
    @(negedge clk);
    op_a = a; op_b = b; start = 1'b1;
    #1;
    chk(stb_clear == 1'b1, "R1 clear strobe on start", longint'(stb_clear), 1);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    #1;
    chk(product == '0, "R1 accumulator cleared", longint'(product), 0);
    while (!done && e <= lat + 4) begin
      if (disturb && e == 1) begin
        start = 1'b1; op_a = ~a; op_b = ~b;
      end
      if (disturb && e == 3) start = 1'b0;
      #1;
      if (stb_add) adds++;
      if (stb_shift) shifts++;
      if (stb_clear) clr_seen = 1;
      @(posedge clk);
      @(negedge clk);
      e++;
    end
    start = 1'b0;
    #1;
    chk(e == lat, "R5 done latency W+ones(op_b)", longint'(e), longint'(lat));
    chk(product == ref_prod(a, b), "R5 product value", longint'(product), longint'(ref_prod(a, b)));
    chk(adds == ones(b), "R9 add strobe count", longint'(adds), longint'(ones(b)));
    chk(shifts == W, "R2 R9 shift strobe count", longint'(shifts), longint'(W));
    if (disturb) chk(!clr_seen, "R6 busy start ignored", longint'(clr_seen), 0);
    held = product;
    @(negedge clk);
    #1;
    chk(done == 1'b0, "R5 done lasts one cycle", longint'(done), 0);
    repeat (3) @(negedge clk);
    #1;
    chk(product == held, "R8 product held after done", longint'(product), longint'(held));
  endtask

  // Watchdog
  initial begin
    #(200000 * 8);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [W-1:0] ra, rb;
    void'($urandom(32'd1357));
    rst_n = 1'b0; start = 1'b0; op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(done == 0 && stb_clear == 0 && stb_add == 0 && stb_shift == 0,
        "R7 reset idle strobes", longint'({done, stb_clear, stb_add, stb_shift}), 0);
    chk(product == '0, "R7 reset product", longint'(product), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Directed corners
    run_op(4'd0,  4'd0,  0);
    run_op(4'd0,  4'd15, 0);
    run_op(4'd15, 4'd0,  0);
    run_op(4'd15, 4'd15, 0);
    run_op(4'd1,  4'd1,  0);
    run_op(4'd15, 4'd8,  0);
    run_op(4'd9,  4'd5,  1);
    run_op(4'd6,  4'd15, 1);

    // Random mix
    for (int n = 0; n < 40; n++) begin
      ra = W'($urandom);
      rb = W'($urandom);
      run_op(ra, rb, n[2]);
    end

    // R7: reset in the middle of a run
    @(negedge clk);
    op_a = 4'd13; op_b = 4'd11; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(done == 0 && stb_add == 0 && stb_shift == 0 && stb_clear == 0,
        "R7 mid-run reset strobes", longint'({done, stb_clear, stb_add, stb_shift}), 0);
    chk(product == '0, "R7 mid-run reset product", longint'(product), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(stb_add == 0 && stb_shift == 0 && done == 0, "R7 idle after reset",
        longint'({done, stb_add, stb_shift}), 0);
    run_op(4'd13, 4'd11, 0);

    finish_run();
  end
endmodule